// File: doc/BRIEF.md
# Four-Wire Serial EEPROM Model

This block is a synthesizable stand-in for a small serial EEPROM of 16-bit words. It is used in simulation or on prototyping hardware in place of a real memory device, behind a host controller that drives chip select, serial clock and data in, and samples data out. The array holds 64 words with a 6-bit address, or 256 words with an 8-bit address, picked by the `ADDR_W` parameter.

All serial pins are sampled in the system clock domain. A rising serial clock edge is seen as a low-to-high change between two system clock samples. A command is a start bit of 1, then a 2-bit opcode, then the address, then 16 data bits where the command carries data. Every field is sent MSB first. Read returns a leading 0 and then the word. Every program or erase command requires an enable latch and starts a busy period of `BUSY_CYCLES` system clocks. A host finds the end of that period by raising chip select again and watching data out.

Top module: `mw_eeprom_model`

## Requirements
- R1: After reset every word reads 16'hFFFF and the program-enable latch is clear.
- R2: Opcode 2'b10 followed by an address is a read. After the last address bit, data out is 0. Each following rising serial clock edge presents the next bit of the addressed word, MSB first.
- R3: Opcode 2'b01 followed by an address and 16 data bits stores the data at that address when the latch is set.
- R4: Opcode 2'b11 followed by an address sets that word to 16'hFFFF when the latch is set.
- R5: Opcode 2'b00 is the extended group, chosen by the two address MSBs. 2'b11 sets the latch and 2'b00 clears it. The low address bits have no effect.
- R6: In the extended group, 2'b10 sets every word to 16'hFFFF, and 2'b01 followed by 16 data bits stores that data in every word. Both require the latch to be set.
- R7: While the latch is clear, write, erase, erase-all and write-all change no word and start no busy period.
- R8: Each accepted program or erase starts a busy period of BUSY_CYCLES system clocks. While idle with chip select high, data out is 0 during that period and 1 after it.
- R9: A start bit that arrives during the busy period is not accepted, so the remaining bits of that command have no effect.
- R10: Taking chip select low at any point abandons a partly received command. The next command after chip select rises again is decoded normally.
- R11: Data out is 0 whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock, acted on at its rising edge |
| di | input | 1 | Serial data from the host |
| dout | output | 1 | Serial read data and ready status |

## Verification
The bench tries to program a word with the latch clear. A design that ignored the latch would change the word and report itself busy at once. It writes the last address, which catches address bits shifted one place too few or too many. It also reads every word back with its leading zero, so a read that is one bit out of alignment shows up as a mismatch. An erase is sent inside the busy period of an earlier write, and a write is cut off by chip select partway through. A model that accepted commands while busy, or that acted on a partial command, would lose the stored value. Enable and disable are sent with non-zero low address bits, so a decoder that wrongly used those bits would leave the latch in the wrong state.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_DONE
    } mw_state_e;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] EX_LOCK  = 2'b00;
    localparam logic [1:0] EX_WALL  = 2'b01;
    localparam logic [1:0] EX_EALL  = 2'b10;
    localparam logic [1:0] EX_OPEN  = 2'b11;

endpackage

// File: rtl/mw_sck_edge.sv
module mw_sck_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic rise
);
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign rise = sck & ~sck_q;
endmodule

// File: rtl/mw_busy_timer.sv
module mw_busy_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (start)              left_d = TW'(CYCLES);
        else if (left_q != '0)  left_d = left_q - TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign busy = (left_q != '0);
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              fill,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] words_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words_q[i] <= '1;
            else if (fill || (we && waddr == ADDR_W'(i)))
                words_q[i] <= wdata;
        end
    end

    assign rdata = words_q[raddr];
endmodule

// File: rtl/mw_eeprom_model.sv
module mw_eeprom_model
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int WORD_W      = 16,
    parameter int BUSY_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sck,
    input  logic di,
    output logic dout
);
    localparam int LONGEST = (ADDR_W > WORD_W) ? ADDR_W : WORD_W;
    localparam int CNT_W   = $clog2(LONGEST + 1);

    typedef struct packed {
        mw_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic [WORD_W:0]   shreg;
        logic              wen;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic              sck_rise;
    logic              busy;
    logic              busy_start;
    logic              mem_we;
    logic              mem_fill;
    logic [ADDR_W-1:0] mem_waddr;
    logic [WORD_W-1:0] mem_wdata;
    logic [WORD_W-1:0] rd_word;
    logic [ADDR_W-1:0] addr_full;
    logic [WORD_W-1:0] data_full;
    logic              prog_any;
    logic              st_idle;

    mw_sck_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sck  (sck),
        .rise (sck_rise)
    );

    mw_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk  (clk),
        .rst_n(rst_n),
        .start(busy_start),
        .busy (busy)
    );

    mw_word_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .fill (mem_fill),
        .waddr(mem_waddr),
        .wdata(mem_wdata),
        .raddr(addr_full),
        .rdata(rd_word)
    );

    // Field values including the bit on di at this edge
    assign addr_full = {cur_q.addr[ADDR_W-2:0], di};
    assign data_full = {cur_q.data[WORD_W-2:0], di};

    always_comb begin
        nxt_d      = cur_q;
        mem_we     = 1'b0;
        mem_fill   = 1'b0;
        mem_waddr  = cur_q.addr;
        mem_wdata  = data_full;
        busy_start = 1'b0;

        if (!cs) begin
            nxt_d.st  = ST_IDLE;
            nxt_d.cnt = '0;
        end else if (sck_rise) begin
            unique case (cur_q.st)
                ST_IDLE: begin
                    if (di && !busy) begin
                        nxt_d.st  = ST_OPC;
                        nxt_d.cnt = '0;
                    end
                end
                ST_OPC: begin
                    nxt_d.op = {cur_q.op[0], di};
                    if (cur_q.cnt == CNT_W'(1)) begin
                        nxt_d.st  = ST_ADDR;
                        nxt_d.cnt = '0;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                    end
                end
                ST_ADDR: begin
                    nxt_d.addr = addr_full;
                    if (cur_q.cnt == CNT_W'(ADDR_W - 1)) begin
                        nxt_d.cnt = '0;
                        nxt_d.st  = ST_DONE;
                        unique case (cur_q.op)
                            OP_READ: begin
                                nxt_d.st    = ST_READ;
                                nxt_d.shreg = {1'b0, rd_word};
                            end
                            OP_WRITE: nxt_d.st = ST_DATA;
                            OP_ERASE: begin
                                if (cur_q.wen) begin
                                    mem_we     = 1'b1;
                                    mem_waddr  = addr_full;
                                    mem_wdata  = '1;
                                    busy_start = 1'b1;
                                end
                            end
                            default: begin
                                unique case (addr_full[ADDR_W-1 -: 2])
                                    EX_OPEN: nxt_d.wen = 1'b1;
                                    EX_LOCK: nxt_d.wen = 1'b0;
                                    EX_EALL: begin
                                        if (cur_q.wen) begin
                                            mem_fill   = 1'b1;
                                            mem_wdata  = '1;
                                            busy_start = 1'b1;
                                        end
                                    end
                                    default: nxt_d.st = ST_DATA;
                                endcase
                            end
                        endcase
                    end else begin
                        nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    nxt_d.data = data_full;
                    if (cur_q.cnt == CNT_W'(WORD_W - 1)) begin
                        nxt_d.st  = ST_DONE;
                        nxt_d.cnt = '0;
                        if (cur_q.wen) begin
                            busy_start = 1'b1;
                            if (cur_q.op == OP_WRITE) mem_we   = 1'b1;
                            else                      mem_fill = 1'b1;
                        end
                    end else begin
                        nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                    end
                end
                ST_READ: nxt_d.shreg = {cur_q.shreg[WORD_W-1:0], 1'b0};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.st    <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        unique case (cur_q.st)
            ST_READ: dout = cs & cur_q.shreg[WORD_W];
            ST_IDLE: dout = cs & ~busy;
            default: dout = 1'b0;
        endcase
    end

    assign prog_any = mem_we | mem_fill;
    assign st_idle  = (cur_q.st == ST_IDLE);
endmodule

// File: rtl/mw_eeprom_checker.sv
module mw_eeprom_checker (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic dout,
    input logic wen,
    input logic prog,
    input logic busy,
    input logic busy_start,
    input logic idle
);
    // R11
    cs_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !dout);

    // R7
    prog_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog |-> wen);

    // R9
    no_prog_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog |-> !busy);

    // R8
    busy_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_start |=> busy);

    // R8
    busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && idle && busy) |-> !dout);
endmodule

bind mw_eeprom_model mw_eeprom_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .dout      (dout),
    .wen       (cur_q.wen),
    .prog      (prog_any),
    .busy      (busy),
    .busy_start(busy_start),
    .idle      (st_idle)
);

// File: tb/mw_eeprom_model_bench.sv
module mw_eeprom_model_bench;
    localparam int BUSY = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sck = 1'b0;
    logic di = 1'b0;
    logic dout;
    logic last_bit;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [16:0] exp_q[$];
    logic [16:0] act_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    mw_eeprom_model #(.ADDR_W(6), .WORD_W(16), .BUSY_CYCLES(BUSY)) u_mw_eeprom_model (
        .clk  (clk),
        .rst_n(rst_n),
        .cs   (cs),
        .sck  (sck),
        .di   (di),
        .dout (dout)
    );

    task automatic check(input logic [16:0] act, input logic [16:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pairs captured reads with expected items
    always @(negedge clk) begin
        if (act_q.size() > 0 && exp_q.size() > 0) begin
            check(act_q.pop_front(), exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_on();
        cs = 1'b1;
        tick(2);
    endtask

    task automatic cs_off();
        sck = 1'b0;
        cs = 1'b0;
        di = 1'b0;
        tick(2);
    endtask

    task automatic bit_out(input logic b);
        di = b;
        tick(2);
        sck = 1'b1;
        tick(2);
        last_bit = dout;
        sck = 1'b0;
    endtask

    task automatic send_head(input logic [1:0] op, input logic [5:0] a);
        bit_out(1'b1);
        bit_out(op[1]);
        bit_out(op[0]);
        for (int i = 5; i >= 0; i--) bit_out(a[i]);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) bit_out(w[i]);
    endtask

    task automatic cmd_write(input logic [5:0] a, input logic [15:0] w);
        cs_on();
        send_head(2'b01, a);
        send_word(w);
        cs_off();
    endtask

    task automatic cmd_erase(input logic [5:0] a);
        cs_on();
        send_head(2'b11, a);
        cs_off();
    endtask

    task automatic cmd_ext(input logic [1:0] sel, input logic [3:0] low);
        cs_on();
        send_head(2'b00, {sel, low});
        cs_off();
    endtask

    task automatic cmd_wall(input logic [15:0] w);
        cs_on();
        send_head(2'b00, 6'b01_0000);
        send_word(w);
        cs_off();
    endtask

    // Driver: pushes the expected stream, then shifts the read out
    task automatic read_word(input logic [5:0] a, input logic [15:0] exp, input string tag);
        logic [16:0] got;
        exp_q.push_back({1'b0, exp});
        tag_q.push_back(tag);
        cs_on();
        send_head(2'b10, a);
        got[16] = last_bit;
        for (int i = 15; i >= 0; i--) begin
            bit_out(1'b0);
            got[i] = last_bit;
        end
        cs_off();
        act_q.push_back(got);
    endtask

    task automatic busy_then_ready(input string tag);
        cs_on();
        check({16'b0, dout}, 17'd0, {tag, " busy low"});
        tick(BUSY + 40);
        check({16'b0, dout}, 17'd1, {tag, " ready high"});
        cs_off();
    endtask

    task automatic ready_now(input string tag);
        cs_on();
        check({16'b0, dout}, 17'd1, tag);
        cs_off();
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        check({16'b0, dout}, 17'd0, "R1 R11 dout low with cs low");
        read_word(6'd5, 16'hFFFF, "R1 R2 reset content");
        read_word(6'd63, 16'hFFFF, "R1 reset content top");

        // R7 latch clear after reset
        cmd_write(6'd3, 16'h1234);
        ready_now("R7 no busy when locked");
        read_word(6'd3, 16'hFFFF, "R7 locked write");
        cmd_erase(6'd4);
        ready_now("R7 locked erase no busy");

        // R5 enable with non-zero low bits
        cmd_ext(2'b11, 4'b1010);
        cmd_write(6'd3, 16'hA5C3);
        busy_then_ready("R8 after write");
        read_word(6'd3, 16'hA5C3, "R3 R2 write readback");
        cmd_write(6'd63, 16'h8001);
        busy_then_ready("R8 top write");
        read_word(6'd63, 16'h8001, "R3 top address");
        read_word(6'd0, 16'hFFFF, "R3 neighbour untouched");

        // R4 erase
        cmd_write(6'd10, 16'h0F0F);
        busy_then_ready("R8 write 10");
        read_word(6'd10, 16'h0F0F, "R3 write 10");
        cmd_erase(6'd10);
        busy_then_ready("R8 erase");
        read_word(6'd10, 16'hFFFF, "R4 erased word");
        read_word(6'd3, 16'hA5C3, "R4 other word kept");

        // R9 erase sent while busy
        cmd_write(6'd20, 16'h1111);
        cmd_erase(6'd20);
        busy_then_ready("R8 R9 busy window");
        read_word(6'd20, 16'h1111, "R9 erase during busy ignored");

        // R10 abort mid-write
        cs_on();
        send_head(2'b01, 6'd7);
        for (int i = 0; i < 5; i++) bit_out(1'b0);
        cs_off();
        read_word(6'd7, 16'hFFFF, "R10 aborted write");
        read_word(6'd20, 16'h1111, "R10 decode after abort");
        ready_now("R10 no busy after abort");

        // R6 write-all then erase-all
        cmd_wall(16'hBEEF);
        busy_then_ready("R8 write-all");
        read_word(6'd0, 16'hBEEF, "R6 write-all low");
        read_word(6'd63, 16'hBEEF, "R6 write-all high");
        cmd_ext(2'b10, 4'b0110);
        busy_then_ready("R8 erase-all");
        read_word(6'd5, 16'hFFFF, "R6 erase-all a");
        read_word(6'd40, 16'hFFFF, "R6 erase-all b");

        // R5 disable with non-zero low bits
        cmd_ext(2'b00, 4'b0101);
        cmd_write(6'd9, 16'h1357);
        ready_now("R5 R7 locked after disable");
        read_word(6'd9, 16'hFFFF, "R5 write after disable");

        tick(5);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule